// File: doc/BRIEF.md
# Strided Column Transfer Engine

This block is a DMA master that moves a column of a row-major matrix between a local word-addressed buffer and a remote processor reached over a request/burst link. The transfer is made of segments that have the same length on both sides. Between segments the engine steps over a programmable stride. The stride can apply on either side. With local striding, the engine gathers segments from scattered local addresses and sends them as one contiguous remote burst. With remote striding, the local data is contiguous and each segment becomes its own link transaction, placed at a strided remote address. The engine is always the master, and the data can flow either way.

Software sets the configuration inputs and pulses `start`. The engine latches the configuration and raises `busy`. It then issues one link request, or one request per segment. It moves words through the local memory port, which has a one-cycle read latency, and through the link data channels. When the transfer is complete it drops `busy` and holds `done` high until the next accepted start.

Top module: `dma_stride_top`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `mem_req`, `lreq_valid`, `tx_valid` and `rx_ready` are all 0.
- R2: If `start` arrives while idle with `cfg_seg_len`==0 or `cfg_seg_cnt`==0, `done` is 1 and `busy` is 0 after the next clock edge. No memory access and no link request takes place.
- R3: With `cfg_mode`=0 (local stride), word i of segment k uses local address lbase + k*(len+stride) + i and remote address rbase + k*len + i.
- R4: With `cfg_mode`=0, exactly one link request is issued, at the start, with address rbase and length len*cnt.
- R5: With `cfg_mode`=1 (remote stride), word i of segment k uses local address lbase + k*len + i and remote address rbase + k*(len+stride) + i. One link request is issued per segment, with address rbase + k*(len+stride) and length len.
- R6: With `cfg_dir`=0, local memory is read and words go out on `tx_data`, and `lreq_send`=1. With `cfg_dir`=1, words taken from `rx_data` are written to local memory, and `lreq_send`=0. Both directions use the address patterns of R3 and R5.
- R7: A word or a request moves only when valid and ready are both high. A pending request holds its address and length, and a pending `tx_data` holds its value, until it is accepted.
- R8: `busy` is 1 from the edge that accepts `start` until the transfer ends. `done` is 1 after the end, until the next accepted start. A `start` while busy is ignored, and the transfer in progress finishes with its original configuration.
- R9: When sending, a link request is never presented while `tx_valid` is high. In remote-stride mode, a segment's request appears only after every word of the previous segment has been delivered.
- R10: Local memory is accessed only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| cfg_lbase | input | AW | Local base address (words) |
| cfg_rbase | input | AW | Remote base address (words) |
| cfg_seg_len | input | LW | Words per segment |
| cfg_stride | input | AW | Words skipped between segments on the striding side |
| cfg_seg_cnt | input | CW | Number of segments |
| cfg_mode | input | 1 | 0 = local stride, 1 = remote stride |
| cfg_dir | input | 1 | 0 = local to remote, 1 = remote to local |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |
| mem_req | output | 1 | Local memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Local word address |
| mem_wdata | output | DW | Local write data |
| mem_rdata | input | DW | Local read data, one cycle after the read |
| lreq_valid | output | 1 | Link request valid |
| lreq_ready | input | 1 | Link request accepted |
| lreq_addr | output | AW | Remote start address of the request |
| lreq_len | output | LW+CW | Request length in words |
| lreq_send | output | 1 | 1 = engine sends data, 0 = engine receives |
| tx_valid | output | 1 | Outbound word valid |
| tx_ready | input | 1 | Outbound word accepted |
| tx_data | output | DW | Outbound word |
| rx_valid | input | 1 | Inbound word valid |
| rx_ready | output | 1 | Engine can take an inbound word |
| rx_data | input | DW | Inbound word |

## Verification
`busy` rises on the edge that accepts `start`, so the bench checks it at the falling edge that follows. In the zero-size case `done` is due on that same edge, and the bench then watches a further window for any memory or link activity. A read issued in one cycle returns its data in the next. The bench's memory model therefore presents read data at the falling edge after the read was seen. Data and address results are checked only after `done` rises. Every handshake is recorded at the falling edge, after the inputs have settled and before the edge that completes it.

// File: rtl/dma_stride_pkg.sv
package dma_stride_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_DATA  = 2'd2,
        ST_DRAIN = 2'd3
    } dma_state_e;

    typedef enum logic {
        MODE_LOCAL_STRIDE  = 1'b0,
        MODE_REMOTE_STRIDE = 1'b1
    } stride_mode_e;

    typedef enum logic {
        DIR_TO_REMOTE   = 1'b0,
        DIR_FROM_REMOTE = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        stride_mode_e mode;
        xfer_dir_e    dir;
    } xfer_kind_t;

    // distance between the first words of two neighbouring segments on the striding side
    function automatic logic [31:0] seg_pitch(input logic [31:0] seg_len, input logic [31:0] stride);
        return seg_len + stride;
    endfunction

endpackage

// File: rtl/dma_stride_addr.sv
module dma_stride_addr
    import dma_stride_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 12,
    parameter int CW = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  stride_mode_e mode,
    input  logic [AW-1:0] lbase,
    input  logic [AW-1:0] rbase,
    input  logic [LW-1:0] seg_len,
    input  logic [AW-1:0] stride,
    output logic [AW-1:0] laddr,
    output logic [AW-1:0] seg_raddr,
    output logic          seg_last,
    output logic [CW-1:0] seg_idx
);

    logic [LW-1:0] wcnt_q;
    logic [CW-1:0] scnt_q;
    logic [AW-1:0] laddr_q;
    logic [AW-1:0] raddr_q;
    logic [AW-1:0] pitch;

    assign pitch     = AW'(seg_pitch(32'(seg_len), 32'(stride)));
    assign seg_last  = (wcnt_q == seg_len - LW'(1));
    assign laddr     = laddr_q;
    assign seg_raddr = raddr_q;
    assign seg_idx   = scnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q  <= '0;
            scnt_q  <= '0;
            laddr_q <= '0;
            raddr_q <= '0;
        end else if (load) begin
            wcnt_q  <= '0;
            scnt_q  <= '0;
            laddr_q <= lbase;
            raddr_q <= rbase;
        end else if (step) begin
            if (seg_last) begin
                wcnt_q  <= '0;
                scnt_q  <= scnt_q + CW'(1);
                raddr_q <= raddr_q + pitch;
                if (mode == MODE_LOCAL_STRIDE)
                    laddr_q <= laddr_q + AW'(1) + stride;
                else
                    laddr_q <= laddr_q + AW'(1);
            end else begin
                wcnt_q  <= wcnt_q + LW'(1);
                laddr_q <= laddr_q + AW'(1);
            end
        end
    end

endmodule

// File: rtl/dma_stride_skid.sv
module dma_stride_skid #(
    parameter int DW    = 32,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_issue,
    input  logic [DW-1:0] rd_data,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          can_issue,
    output logic          drained
);

    // DEPTH must be a power of two so the pointers wrap by themselves
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int LDW  = CNTW + 1;

    logic [DW-1:0]   buf_q [DEPTH];
    logic [PW-1:0]   wr_q, rd_q;
    logic [CNTW-1:0] occ_q;
    logic            inflight_q;
    logic            push, pop;
    logic [LDW-1:0]  load_c;

    assign push      = inflight_q;
    assign out_valid = (occ_q != '0);
    assign out_data  = buf_q[rd_q];
    assign pop       = out_valid && out_ready;
    assign load_c    = {1'b0, occ_q} + LDW'(inflight_q) - LDW'(pop);
    assign can_issue = (load_c < LDW'(DEPTH));
    assign drained   = (occ_q == '0) && !inflight_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q       <= '0;
            rd_q       <= '0;
            occ_q      <= '0;
            inflight_q <= 1'b0;
        end else begin
            inflight_q <= rd_issue;
            if (push) wr_q <= wr_q + PW'(1);
            if (pop)  rd_q <= rd_q + PW'(1);
            occ_q <= occ_q + CNTW'(push) - CNTW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) buf_q[wr_q] <= rd_data;
    end

endmodule

// File: rtl/dma_stride_top.sv
module dma_stride_top
    import dma_stride_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int LW         = 12,
    parameter int CW         = 12,
    parameter int SKID_DEPTH = 2,
    localparam int TLW       = LW + CW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [AW-1:0]  cfg_lbase,
    input  logic [AW-1:0]  cfg_rbase,
    input  logic [LW-1:0]  cfg_seg_len,
    input  logic [AW-1:0]  cfg_stride,
    input  logic [CW-1:0]  cfg_seg_cnt,
    input  logic           cfg_mode,
    input  logic           cfg_dir,
    output logic           busy,
    output logic           done,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic           lreq_valid,
    input  logic           lreq_ready,
    output logic [AW-1:0]  lreq_addr,
    output logic [TLW-1:0] lreq_len,
    output logic           lreq_send,
    output logic           tx_valid,
    input  logic           tx_ready,
    output logic [DW-1:0]  tx_data,
    input  logic           rx_valid,
    output logic           rx_ready,
    input  logic [DW-1:0]  rx_data
);

    dma_state_e    state_q, state_d;
    xfer_kind_t    kind_q;
    logic [LW-1:0] len_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] stride_q;
    logic          done_q;

    logic          accept, zero_size, is_tx, beat, finish;
    logic          can_issue, drained, seg_last, last_word;
    logic [AW-1:0] laddr, seg_raddr;
    logic [CW-1:0] seg_idx;

    assign accept    = start && (state_q == ST_IDLE);
    assign zero_size = (cfg_seg_len == '0) || (cfg_seg_cnt == '0);
    assign is_tx     = (kind_q.dir == DIR_TO_REMOTE);
    assign beat      = (state_q == ST_DATA) && (is_tx ? can_issue : rx_valid);
    assign last_word = seg_last && (seg_idx == cnt_q - CW'(1));

    dma_stride_addr #(.AW(AW), .LW(LW), .CW(CW)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (accept && !zero_size),
        .step      (beat),
        .mode      (kind_q.mode),
        .lbase     (cfg_lbase),
        .rbase     (cfg_rbase),
        .seg_len   (len_q),
        .stride    (stride_q),
        .laddr     (laddr),
        .seg_raddr (seg_raddr),
        .seg_last  (seg_last),
        .seg_idx   (seg_idx)
    );

    dma_stride_skid #(.DW(DW), .DEPTH(SKID_DEPTH)) u_skid (
        .clk       (clk),
        .rst       (rst),
        .rd_issue  (beat && is_tx),
        .rd_data   (mem_rdata),
        .out_ready (tx_ready),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .can_issue (can_issue),
        .drained   (drained)
    );

    always_comb begin
        state_d = state_q;
        finish  = 1'b0;
        case (state_q)
            ST_IDLE:  if (accept && !zero_size) state_d = ST_REQ;
            ST_REQ:   if (lreq_ready) state_d = ST_DATA;
            ST_DATA: begin
                if (beat && seg_last) begin
                    if (is_tx) begin
                        if (last_word || kind_q.mode == MODE_REMOTE_STRIDE) state_d = ST_DRAIN;
                    end else if (last_word) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end else if (kind_q.mode == MODE_REMOTE_STRIDE) begin
                        state_d = ST_REQ;
                    end
                end
            end
            ST_DRAIN: begin
                if (drained) begin
                    if (seg_idx == cnt_q) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end else begin
                        state_d = ST_REQ;
                    end
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            kind_q   <= '{mode: MODE_LOCAL_STRIDE, dir: DIR_TO_REMOTE};
            len_q    <= '0;
            cnt_q    <= '0;
            stride_q <= '0;
            done_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q   <= '{mode: stride_mode_e'(cfg_mode), dir: xfer_dir_e'(cfg_dir)};
                len_q    <= cfg_seg_len;
                cnt_q    <= cfg_seg_cnt;
                stride_q <= cfg_stride;
                done_q   <= zero_size;
            end else if (finish) begin
                done_q   <= 1'b1;
            end
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign mem_req    = beat;
    assign mem_we     = !is_tx;
    assign mem_addr   = laddr;
    assign mem_wdata  = rx_data;
    assign rx_ready   = (state_q == ST_DATA) && !is_tx;
    assign lreq_valid = (state_q == ST_REQ);
    assign lreq_addr  = seg_raddr;
    assign lreq_send  = is_tx;
    assign lreq_len   = (kind_q.mode == MODE_REMOTE_STRIDE) ? TLW'(len_q)
                                                            : TLW'(len_q) * TLW'(cnt_q);

endmodule

// File: rtl/dma_stride_chk.sv
module dma_stride_chk #(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int LW  = 12,
    parameter int CW  = 12,
    parameter int TLW = 24
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [LW-1:0]  cfg_seg_len,
    input logic [CW-1:0]  cfg_seg_cnt,
    input logic           busy,
    input logic           done,
    input logic           mem_req,
    input logic           lreq_valid,
    input logic           lreq_ready,
    input logic [AW-1:0]  lreq_addr,
    input logic [TLW-1:0] lreq_len,
    input logic           tx_valid,
    input logic           tx_ready,
    input logic [DW-1:0]  tx_data,
    input logic           rx_ready
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!lreq_valid && !tx_valid && !rx_ready && !mem_req));

    p_zero_done_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (cfg_seg_len == '0 || cfg_seg_cnt == '0)) |=> (done && !busy));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (lreq_valid && !lreq_ready) |=> (lreq_valid && $stable(lreq_addr) && $stable(lreq_len)));

    p_tx_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && cfg_seg_len != '0 && cfg_seg_cnt != '0) |=> (busy && !done));

    p_req_no_data_r9: assert property (@(posedge clk) disable iff (rst)
        lreq_valid |-> !tx_valid);

    p_mem_busy_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

endmodule

bind dma_stride_top dma_stride_chk #(.AW(AW), .DW(DW), .LW(LW), .CW(CW), .TLW(TLW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .cfg_seg_len (cfg_seg_len),
    .cfg_seg_cnt (cfg_seg_cnt),
    .busy        (busy),
    .done        (done),
    .mem_req     (mem_req),
    .lreq_valid  (lreq_valid),
    .lreq_ready  (lreq_ready),
    .lreq_addr   (lreq_addr),
    .lreq_len    (lreq_len),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .rx_ready    (rx_ready)
);

// File: tb/sim_dma_stride_top.sv
module sim_dma_stride_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LW = 12;
    localparam int CW = 12;
    localparam int TLW = LW + CW;
    localparam int MSZ = 1024;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [AW-1:0]  cfg_lbase = '0, cfg_rbase = '0, cfg_stride = '0;
    logic [LW-1:0]  cfg_seg_len = '0;
    logic [CW-1:0]  cfg_seg_cnt = '0;
    logic           cfg_mode = 1'b0, cfg_dir = 1'b0;
    logic           busy, done, mem_req, mem_we;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata;
    logic [DW-1:0]  mem_rdata = '0;
    logic           lreq_valid, lreq_send;
    logic           lreq_ready = 1'b0;
    logic [AW-1:0]  lreq_addr;
    logic [TLW-1:0] lreq_len;
    logic           tx_valid, rx_ready;
    logic           tx_ready = 1'b0;
    logic [DW-1:0]  tx_data;
    logic           rx_valid = 1'b0;
    logic [DW-1:0]  rx_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_stride_top #(.AW(AW), .DW(DW), .LW(LW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .cfg_lbase(cfg_lbase), .cfg_rbase(cfg_rbase), .cfg_seg_len(cfg_seg_len),
        .cfg_stride(cfg_stride), .cfg_seg_cnt(cfg_seg_cnt), .cfg_mode(cfg_mode), .cfg_dir(cfg_dir),
        .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .lreq_valid(lreq_valid), .lreq_ready(lreq_ready), .lreq_addr(lreq_addr), .lreq_len(lreq_len),
        .lreq_send(lreq_send),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
    );

    int total = 0;
    int bad = 0;

    logic [DW-1:0] lmem [MSZ];
    logic [DW-1:0] rmem [MSZ];
    int  req_addr [64];
    int  req_len  [64];
    int  req_send [64];
    int  nreq = 0, nmem = 0, ntx = 0, nrx = 0;
    int  tptr = 0, rptr = 0, rx_left = 0;
    logic [DW-1:0] pend_rdata = '0;
    bit  model_on = 1'b0;

    function automatic logic [DW-1:0] lpat(input int a);
        return 32'h5A00_0000 | DW'(a * 13 + 7);
    endfunction

    function automatic logic [DW-1:0] rsrc(input int a);
        return 32'hC300_0000 | DW'(a * 29 + 3);
    endfunction

    function automatic int exp_laddr(input int mode, input int lb, input int len, input int str,
                                     input int k, input int i);
        return (mode == 0) ? lb + k * (len + str) + i : lb + k * len + i;
    endfunction

    function automatic int exp_raddr(input int mode, input int rb, input int len, input int str,
                                     input int k, input int i);
        return (mode == 0) ? rb + k * len + i : rb + k * (len + str) + i;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // link and memory model: inputs set at the falling edge, handshakes recorded after settling
    initial begin
        forever begin
            @(negedge clk);
            mem_rdata  = pend_rdata;
            lreq_ready = model_on && ($urandom_range(0, 3) != 0);
            tx_ready   = model_on && ($urandom_range(0, 3) != 0);
            rx_valid   = model_on && (rx_left > 0) && ($urandom_range(0, 3) != 0);
            rx_data    = rsrc(rptr);
            #1;
            if (lreq_valid && lreq_ready) begin
                if (nreq < 64) begin
                    req_addr[nreq] = int'(lreq_addr);
                    req_len[nreq]  = int'(lreq_len);
                    req_send[nreq] = int'(lreq_send);
                end
                nreq++;
                if (lreq_send) tptr = int'(lreq_addr);
                else begin
                    rptr    = int'(lreq_addr);
                    rx_left = int'(lreq_len);
                end
            end
            if (tx_valid && tx_ready) begin
                rmem[tptr % MSZ] = tx_data;
                tptr++;
                ntx++;
            end
            if (rx_valid && rx_ready) begin
                rptr++;
                rx_left--;
                nrx++;
            end
            if (mem_req) begin
                nmem++;
                if (mem_we) lmem[int'(mem_addr) % MSZ] = mem_wdata;
                else        pend_rdata = lmem[int'(mem_addr) % MSZ];
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic run_xfer(input int mode, input int dir, input int lb, input int rb,
                            input int len, input int str, input int cnt, input bit poke);
        int waited;
        int mism;
        int first_a;
        int first_e;
        int la;
        int ra;
        for (int a = 0; a < MSZ; a++) begin
            lmem[a] = (dir == 0) ? lpat(a) : 32'hDEAD_BEEF;
            rmem[a] = 32'hDEAD_BEEF;
        end
        nreq = 0; ntx = 0; nrx = 0; rx_left = 0;
        @(negedge clk);
        cfg_mode = mode[0]; cfg_dir = dir[0];
        cfg_lbase = AW'(lb); cfg_rbase = AW'(rb);
        cfg_seg_len = LW'(len); cfg_stride = AW'(str); cfg_seg_cnt = CW'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && done == 1'b0, "R8", int'(busy), 1, "busy after start");
        if (poke) begin
            repeat (2) @(negedge clk);
            // R8: a start while busy must not disturb the transfer
            cfg_lbase = AW'(lb + 5); cfg_seg_len = LW'(len + 1); cfg_seg_cnt = CW'(cnt + 2);
            cfg_mode = ~mode[0]; cfg_dir = ~dir[0];
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1 && busy == 1'b0, "R8", int'(done), 1, "done after transfer");
        mism = 0; first_a = 0; first_e = 0;
        for (int k = 0; k < cnt; k++) begin
            for (int i = 0; i < len; i++) begin
                la = exp_laddr(mode, lb, len, str, k, i);
                ra = exp_raddr(mode, rb, len, str, k, i);
                if (dir == 0 && rmem[ra % MSZ] != lpat(la)) begin
                    if (mism == 0) begin first_a = int'(rmem[ra % MSZ]); first_e = int'(lpat(la)); end
                    mism++;
                end
                if (dir == 1 && lmem[la % MSZ] != rsrc(ra)) begin
                    if (mism == 0) begin first_a = int'(lmem[la % MSZ]); first_e = int'(rsrc(ra)); end
                    mism++;
                end
            end
        end
        if (mode == 0) check(mism == 0, "R3", first_a, first_e, "local-stride data placement");
        else           check(mism == 0, "R5", first_a, first_e, "remote-stride data placement");
        if (dir == 0) check(ntx == len * cnt, "R6", ntx, len * cnt, "words sent");
        else          check(nrx == len * cnt, "R6", nrx, len * cnt, "words received");
        if (mode == 0) begin
            check(nreq == 1, "R4", nreq, 1, "request count");
            check(req_addr[0] == rb && req_len[0] == len * cnt, "R4", req_len[0], len * cnt, "request length");
        end else begin
            check(nreq == cnt, "R5", nreq, cnt, "request count");
            for (int k = 0; k < cnt && k < 64; k++)
                check(req_addr[k] == rb + k * (len + str) && req_len[k] == len, "R5",
                      req_addr[k], rb + k * (len + str), "segment request address");
        end
        check(req_send[0] == ((dir == 0) ? 1 : 0), "R6", req_send[0], (dir == 0) ? 1 : 0, "request direction");
    endtask

    task automatic run_zero(input int len, input int cnt);
        int m0;
        int r0;
        m0 = nmem; r0 = nreq;
        @(negedge clk);
        cfg_seg_len = LW'(len); cfg_seg_cnt = CW'(cnt);
        cfg_mode = 1'b0; cfg_dir = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1 && busy == 1'b0, "R2", int'(done), 1, "zero-size done");
        repeat (6) @(negedge clk);
        check(nmem == m0 && nreq == r0, "R2", nmem - m0 + nreq - r0, 0, "zero-size activity");
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_req && !lreq_valid && !tx_valid && !rx_ready,
              "R1", int'(busy) + int'(done) + int'(mem_req), 0, "reset state");
        model_on = 1'b1;

        run_zero(0, 3);
        run_zero(4, 0);

        run_xfer(0, 0, 10, 100, 1, 7, 5, 1'b0);
        run_xfer(1, 0, 20, 200, 3, 4, 4, 1'b1);
        run_xfer(0, 1, 0, 300, 2, 8, 6, 1'b0);
        run_xfer(1, 1, 50, 0, 4, 0, 3, 1'b1);
        run_xfer(1, 0, 7, 9, 1, 0, 1, 1'b0);
        run_zero(0, 0);

        for (int n = 0; n < 40; n++) begin
            run_xfer(int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                     int'($urandom_range(0, 63)), int'($urandom_range(0, 63)),
                     int'($urandom_range(1, 4)), int'($urandom_range(0, 9)),
                     int'($urandom_range(1, 6)), ($urandom_range(0, 3) == 0));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule